// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes received Ethernet frames as a byte stream. Each byte arrives with a valid strobe. The final byte carries a last flag, error flags and address-class hits. The block stores each frame in a circular byte ring in memory through a 32-bit write port with byte enables. Every stored frame sits behind a 4-byte little-endian header. The header's low half holds the receive status and its high half holds the frame length, FCS included. Frame starts are always 4-byte aligned. A frame's data is written first and its header last, so software never sees a header whose data is still missing.

The block owns the write offset. Software reports how far it has read by writing its read offset minus 16 into a read-pointer register. The block raises an empty flag when the two positions coincide. A frame is stored only when its address class is enabled and it carries no error flag. A frame that would run into unread data is discarded whole and raises a ring-overflow status bit. The ring is 8, 16 or 32 KiB. The data may either wrap to offset zero at the ring end or run on past the end into slack memory.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset, wr_offset is 0, buf_empty is 1, irq_status is 0 and mem_we is 0.
- R2: Byte k of a frame (k counted from 0) is written to byte address wr_offset+4+k, unless R8, R11 or R12 suppresses it. The write appears as mem_waddr = address>>2, a one-hot mem_be with bit (address mod 4) set, and the byte replicated into all four lanes of mem_wdata.
- R3: For an accepted frame, the header is written one cycle after the cycle of its last byte. The write goes to word wr_offset>>2 with mem_be=4'hF and mem_wdata = {length[15:0], status[15:0]}. Status bit 15 is the multicast hit, bit 14 the own-address hit, bit 13 the broadcast hit, bit 0 is 1, and all other bits are 0.
- R4: With the header write, wr_offset becomes (wr_offset + round_up4(4 + length)) mod ring size. It changes at no other time, apart from reset.
- R5: The ring size is 8192 << cfg_size_sel, with select values 0, 1 and 2. With cfg_run_past at 0, data byte addresses are taken mod ring size.
- R6: With cfg_run_past at 1, data byte addresses are not reduced and continue past the ring end. The write offset is still reduced mod ring size.
- R7: The read position is (host_rd_val + 16) mod ring size, taken from the last write to the register; it resets to 0. buf_empty is 1 exactly when the read position equals wr_offset.
- R8: Let free be the distance from wr_offset forward to the read position, with ring size when they are equal. Byte k is written only if round_up4(k+5) < free held for every byte so far. An accepted frame that failed this test produces no header, leaves wr_offset unchanged and sets irq_status bit 4.
- R9: A frame is accepted only if at least one of these holds: own hit with cfg_take_own, multicast hit with cfg_take_mcast, broadcast hit with cfg_take_bcast. It must also have all rx_err bits at 0. A rejected frame writes no header, leaves wr_offset unchanged and sets no status bit.
- R10: irq_status bit 0 is set together with an accepted frame's header write. Writing 1 to a bit through irq_ack_we/irq_ack_bits clears it; a set in the same cycle wins.
- R11: A byte presented in the cycle right after a last byte is lost. It sets irq_status bit 6, and the frame it belongs to gets no header and no pointer advance.
- R12: Bytes at index MAX_FRAME and above are not written. Such an oversize frame is dropped with no header, no pointer change and no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size_sel | input | 2 | Ring size select: 8 KiB << value |
| cfg_take_own | input | 1 | Accept frames addressed to this station |
| cfg_take_mcast | input | 1 | Accept multicast frames |
| cfg_take_bcast | input | 1 | Accept broadcast frames |
| cfg_run_past | input | 1 | Let frame data run past the ring end |
| rx_valid | input | 1 | Byte strobe |
| rx_byte | input | 8 | Frame byte |
| rx_last | input | 1 | Final byte of frame |
| rx_err | input | 5 | Error flags, valid with rx_last |
| rx_hit_own | input | 1 | Own-address match, valid with rx_last |
| rx_hit_mcast | input | 1 | Multicast destination, valid with rx_last |
| rx_hit_bcast | input | 1 | Broadcast destination, valid with rx_last |
| host_rd_we | input | 1 | Read-pointer register write |
| host_rd_val | input | 16 | Read offset minus 16 |
| irq_ack_we | input | 1 | Status clear strobe |
| irq_ack_bits | input | 16 | Write-1-to-clear mask |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | 15 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| wr_offset | output | 16 | Current write offset in the ring |
| buf_empty | output | 1 | Ring holds no unread frame |
| irq_status | output | 16 | Status: bit 0 receive OK, bit 4 ring overflow, bit 6 byte lost |

## Verification
A data byte's memory write shows on the port one clock after the edge that takes the byte. A frame's header write, its new write offset and its status bits show one clock later, in the cycle after the last byte's edge. buf_empty follows a read-pointer write by one clock, and a status clear shows one clock after its strobe. The bench drives inputs on falling edges and samples the outputs on the falling edge after the edge that made them. Each result is checked exactly in its due half-cycle, against offsets, free space and lane positions that the bench computes from the requirements alone.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  // Pointer width covers a 32 KiB ring plus run-past slack.
  localparam int PTR_W = 17;
  localparam int WA_W  = PTR_W - 2;
  typedef logic [PTR_W-1:0] ptr_t;

  localparam logic [1:0]  MAX_SEL  = 2'd2;
  localparam logic [15:0] HOST_RST = 16'hFFF0;
  localparam int ST_RXOK = 0;
  localparam int ST_RING = 4;
  localparam int ST_LOST = 6;

  function automatic ptr_t ring_bytes(input logic [1:0] sel);
    logic [1:0] s;
    s = (sel > MAX_SEL) ? MAX_SEL : sel;
    return ptr_t'(17'd8192) << s;
  endfunction

  function automatic ptr_t round_up4(input ptr_t x);
    ptr_t y;
    y = x + ptr_t'(3);
    return {y[PTR_W-1:2], 2'b00};
  endfunction

  function automatic ptr_t ring_adv(input ptr_t base, input ptr_t step, input ptr_t size);
    return (base + step) & (size - ptr_t'(1));
  endfunction

  // Distance forward from wr to rd; a full ring when they meet.
  function automatic ptr_t ring_free(input ptr_t wr, input ptr_t rd, input ptr_t size);
    ptr_t d;
    d = (rd - wr) & (size - ptr_t'(1));
    return (d == '0) ? size : d;
  endfunction
endpackage

// File: rtl/rxr_rd_track.sv
module rxr_rd_track import rxr_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  ptr_t        ring_size,
  input  ptr_t        wr_pos,
  input  logic        host_we,
  input  logic [15:0] host_val,
  output ptr_t        rd_pos,
  output ptr_t        free_bytes,
  output logic        empty
);
  logic [15:0] host_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       host_q <= HOST_RST;
    else if (host_we) host_q <= host_val;
  end

  assign rd_pos     = ring_adv({1'b0, host_q}, ptr_t'(16), ring_size);
  assign free_bytes = ring_free(wr_pos, rd_pos, ring_size);
  assign empty      = (rd_pos == wr_pos);
endmodule

// File: rtl/rxr_irq.sv
module rxr_irq import rxr_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_ok,
  input  logic        set_ring,
  input  logic        set_lost,
  input  logic        ack_we,
  input  logic [15:0] ack_bits,
  output logic [15:0] status
);
  logic [15:0] set_v, clr_v, q;

  always_comb begin
    set_v          = '0;
    set_v[ST_RXOK] = set_ok;
    set_v[ST_RING] = set_ring;
    set_v[ST_LOST] = set_lost;
    clr_v          = ack_we ? ack_bits : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_v) | set_v;
  end

  assign status = q;
endmodule

// File: rtl/rxr_frame_wr.sv
module rxr_frame_wr import rxr_pkg::*; #(
  parameter int MAX_FRAME = 2048
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ptr_t            ring_size,
  input  logic            run_past,
  input  logic            take_own,
  input  logic            take_mcast,
  input  logic            take_bcast,
  input  logic            rx_valid,
  input  logic [7:0]      rx_byte,
  input  logic            rx_last,
  input  logic [4:0]      rx_err,
  input  logic            hit_own,
  input  logic            hit_mcast,
  input  logic            hit_bcast,
  input  ptr_t            free_bytes,
  output ptr_t            wr_pos,
  output logic            mem_we,
  output logic [WA_W-1:0] mem_waddr,
  output logic [31:0]     mem_wdata,
  output logic [3:0]      mem_be,
  output logic            busy,
  output logic            byte_lost,
  output logic            commit_ok,
  output logic            commit_ovf
);
  logic [15:0] cnt;
  logic        drop_sp, drop_lost, drop_big;
  logic        pend_q, pend_ok_q, pend_ovf_q;
  logic [15:0] pend_len_q, pend_stat_q;
  ptr_t        wr_q;
  logic        we_q;
  logic [WA_W-1:0] waddr_q;
  logic [31:0] wdata_q;
  logic [3:0]  be_q;

  // Per-byte decisions.
  ptr_t cnt_p, need, raw_addr, byte_addr, step;
  logic fits, big_now, wr_byte, filt, bad, sp, big, base_ok, good, ovf;

  always_comb begin
    cnt_p     = {1'b0, cnt};
    need      = round_up4(cnt_p + ptr_t'(5));
    fits      = need < free_bytes;
    big_now   = int'(cnt) >= MAX_FRAME;
    raw_addr  = wr_q + ptr_t'(4) + cnt_p;
    byte_addr = run_past ? raw_addr : (raw_addr & (ring_size - ptr_t'(1)));
    wr_byte   = rx_valid && !pend_q && fits && !drop_sp && !drop_lost
                && !drop_big && !big_now;
    filt      = (hit_own & take_own) | (hit_mcast & take_mcast) | (hit_bcast & take_bcast);
    bad       = |rx_err;
    sp        = drop_sp | ~fits;
    big       = drop_big | big_now;
    base_ok   = filt & ~bad & ~big & ~drop_lost;
    good      = base_ok & ~sp;
    ovf       = base_ok & sp;
    step      = round_up4({1'b0, pend_len_q} + ptr_t'(4));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; drop_sp <= 1'b0; drop_lost <= 1'b0; drop_big <= 1'b0;
      pend_q <= 1'b0; pend_ok_q <= 1'b0; pend_ovf_q <= 1'b0;
      pend_len_q <= '0; pend_stat_q <= '0; wr_q <= '0;
      we_q <= 1'b0; waddr_q <= '0; wdata_q <= '0; be_q <= '0;
    end else begin
      we_q   <= 1'b0;
      pend_q <= 1'b0;
      if (pend_q) begin
        // Commit slot: header goes out last, pointer moves with it.
        if (pend_ok_q) begin
          we_q    <= 1'b1;
          waddr_q <= wr_q[PTR_W-1:2];
          wdata_q <= {pend_len_q, pend_stat_q};
          be_q    <= 4'hF;
          wr_q    <= ring_adv(wr_q, step, ring_size);
        end
        if (rx_valid) begin
          if (rx_last) begin
            cnt <= '0; drop_sp <= 1'b0; drop_lost <= 1'b0; drop_big <= 1'b0;
          end else begin
            drop_lost <= 1'b1;
          end
        end
      end else if (rx_valid) begin
        if (wr_byte) begin
          we_q    <= 1'b1;
          waddr_q <= byte_addr[PTR_W-1:2];
          wdata_q <= {4{rx_byte}};
          be_q    <= 4'b0001 << byte_addr[1:0];
        end
        if (rx_last) begin
          pend_q      <= 1'b1;
          pend_ok_q   <= good;
          pend_ovf_q  <= ovf;
          pend_len_q  <= cnt + 16'd1;
          pend_stat_q <= {hit_mcast, hit_own, hit_bcast, 12'd0, 1'b1};
          cnt <= '0; drop_sp <= 1'b0; drop_lost <= 1'b0; drop_big <= 1'b0;
        end else begin
          cnt <= (cnt == 16'hFFFF) ? cnt : cnt + 16'd1;
          if (!fits)  drop_sp  <= 1'b1;
          if (big_now) drop_big <= 1'b1;
        end
      end
    end
  end

  assign wr_pos     = wr_q;
  assign mem_we     = we_q;
  assign mem_waddr  = waddr_q;
  assign mem_wdata  = wdata_q;
  assign mem_be     = be_q;
  assign busy       = pend_q;
  assign byte_lost  = rx_valid & pend_q;
  assign commit_ok  = pend_q & pend_ok_q;
  assign commit_ovf = pend_q & pend_ovf_q;
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer import rxr_pkg::*; #(
  parameter int MAX_FRAME = 2048
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_size_sel,
  input  logic            cfg_take_own,
  input  logic            cfg_take_mcast,
  input  logic            cfg_take_bcast,
  input  logic            cfg_run_past,
  input  logic            rx_valid,
  input  logic [7:0]      rx_byte,
  input  logic            rx_last,
  input  logic [4:0]      rx_err,
  input  logic            rx_hit_own,
  input  logic            rx_hit_mcast,
  input  logic            rx_hit_bcast,
  input  logic            host_rd_we,
  input  logic [15:0]     host_rd_val,
  input  logic            irq_ack_we,
  input  logic [15:0]     irq_ack_bits,
  output logic            mem_we,
  output logic [WA_W-1:0] mem_waddr,
  output logic [31:0]     mem_wdata,
  output logic [3:0]      mem_be,
  output logic [15:0]     wr_offset,
  output logic            buf_empty,
  output logic [15:0]     irq_status
);
  ptr_t ring_size, wr_pos, rd_pos, free_bytes;
  logic busy_w, lost_w, commit_ok_w, commit_ovf_w;

  assign ring_size = ring_bytes(cfg_size_sel);

  rxr_rd_track u_rd (
    .clk(clk), .rst_n(rst_n), .ring_size(ring_size), .wr_pos(wr_pos),
    .host_we(host_rd_we), .host_val(host_rd_val),
    .rd_pos(rd_pos), .free_bytes(free_bytes), .empty(buf_empty)
  );

  rxr_frame_wr #(.MAX_FRAME(MAX_FRAME)) u_wr (
    .clk(clk), .rst_n(rst_n), .ring_size(ring_size), .run_past(cfg_run_past),
    .take_own(cfg_take_own), .take_mcast(cfg_take_mcast), .take_bcast(cfg_take_bcast),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last), .rx_err(rx_err),
    .hit_own(rx_hit_own), .hit_mcast(rx_hit_mcast), .hit_bcast(rx_hit_bcast),
    .free_bytes(free_bytes), .wr_pos(wr_pos),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .busy(busy_w), .byte_lost(lost_w), .commit_ok(commit_ok_w), .commit_ovf(commit_ovf_w)
  );

  rxr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_ok(commit_ok_w), .set_ring(commit_ovf_w),
    .set_lost(lost_w), .ack_we(irq_ack_we), .ack_bits(irq_ack_bits),
    .status(irq_status)
  );

  assign wr_offset = wr_pos[15:0];
endmodule

// File: rtl/rxr_ring_writer_chk.sv
module rxr_ring_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        busy,
  input logic        commit_ok,
  input logic        commit_ovf,
  input logic        mem_we,
  input logic [3:0]  mem_be,
  input logic [15:0] wr_offset,
  input logic [15:0] irq_status,
  input logic        ack_we,
  input logic [15:0] ack_bits
);
  // R3: a commit is followed by a full-word header write.
  a_r3_header_word: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |=> (mem_we && mem_be == 4'hF));
  // R4: the write offset stays 4-byte aligned.
  a_r4_wr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_offset[1:0] == 2'b00);
  // R4: the offset moves only on a commit.
  a_r4_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ok |=> $stable(wr_offset));
  // R8: an overflowed frame leaves the offset unchanged and flags bit 4.
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ovf |=> ($stable(wr_offset) && irq_status[4]));
  // R10: a commit sets bit 0.
  a_r10_rx_ok_set: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |=> irq_status[0]);
  // R10: clearing bit 0 without a concurrent set.
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && ack_bits[0] && !commit_ok) |=> !irq_status[0]);
  // R11: a byte during the commit slot flags bit 6.
  a_r11_lost_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && busy) |=> irq_status[6]);
endmodule

bind rxr_ring_writer rxr_ring_writer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .busy(busy_w),
  .commit_ok(commit_ok_w), .commit_ovf(commit_ovf_w), .mem_we(mem_we),
  .mem_be(mem_be), .wr_offset(wr_offset), .irq_status(irq_status),
  .ack_we(irq_ack_we), .ack_bits(irq_ack_bits)
);

// File: tb/rxr_ring_writer_tb_top.sv
module rxr_ring_writer_tb_top;
  localparam int MAXF = 2048;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [1:0]  cfg_size_sel;
  logic        cfg_take_own, cfg_take_mcast, cfg_take_bcast, cfg_run_past;
  logic        rx_valid, rx_last, rx_hit_own, rx_hit_mcast, rx_hit_bcast;
  logic [7:0]  rx_byte;
  logic [4:0]  rx_err;
  logic        host_rd_we, irq_ack_we;
  logic [15:0] host_rd_val, irq_ack_bits;
  logic        mem_we, buf_empty;
  logic [14:0] mem_waddr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic [15:0] wr_offset, irq_status;

  rxr_ring_writer #(.MAX_FRAME(MAXF)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_size_sel(cfg_size_sel),
    .cfg_take_own(cfg_take_own), .cfg_take_mcast(cfg_take_mcast),
    .cfg_take_bcast(cfg_take_bcast), .cfg_run_past(cfg_run_past),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last), .rx_err(rx_err),
    .rx_hit_own(rx_hit_own), .rx_hit_mcast(rx_hit_mcast), .rx_hit_bcast(rx_hit_bcast),
    .host_rd_we(host_rd_we), .host_rd_val(host_rd_val),
    .irq_ack_we(irq_ack_we), .irq_ack_bits(irq_ack_bits),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .wr_offset(wr_offset), .buf_empty(buf_empty), .irq_status(irq_status)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int unsigned m_wr, m_rd, m_size;
  bit [15:0] m_irq;
  bit m_past;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned free_of();
    if (m_rd == m_wr) return m_size;
    if (m_rd > m_wr)  return m_rd - m_wr;
    return m_size - m_wr + m_rd;
  endfunction

  function automatic int unsigned foot(input int unsigned n);
    return ((n + 3) / 4) * 4;
  endfunction

  task automatic check_state(input string tag);
    chk(wr_offset == 16'(m_wr), {tag, " wr_offset"}, wr_offset, m_wr);
    chk(irq_status == m_irq, {tag, " irq_status"}, irq_status, m_irq);
    chk(buf_empty == (m_rd == m_wr), {tag, " buf_empty"}, buf_empty, (m_rd == m_wr));
  endtask

  task automatic do_reset(input logic [1:0] sel);
    rst_n = 0; cfg_size_sel = sel; cfg_run_past = 0;
    cfg_take_own = 1; cfg_take_mcast = 1; cfg_take_bcast = 1;
    rx_valid = 0; rx_byte = 0; rx_last = 0; rx_err = 0;
    rx_hit_own = 0; rx_hit_mcast = 0; rx_hit_bcast = 0;
    host_rd_we = 0; host_rd_val = 0; irq_ack_we = 0; irq_ack_bits = 0;
    m_size = 32'd8192 << sel; m_wr = 0; m_rd = 0; m_irq = 0; m_past = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(wr_offset == 0, "R1 wr_offset after reset", wr_offset, 0);
    chk(buf_empty == 1, "R1 buf_empty after reset", buf_empty, 1);
    chk(irq_status == 0, "R1 irq_status after reset", irq_status, 0);
    chk(mem_we == 0, "R1 mem_we after reset", mem_we, 0);
  endtask

  task automatic host_set(input int unsigned pos);
    @(negedge clk);
    host_rd_we = 1; host_rd_val = 16'(pos - 16);
    @(negedge clk);
    host_rd_we = 0;
    m_rd = pos % m_size;
    chk(buf_empty == (m_rd == m_wr), "R7 buf_empty after read-pointer write", buf_empty, (m_rd == m_wr));
  endtask

  task automatic ack(input bit [15:0] bits);
    @(negedge clk);
    irq_ack_we = 1; irq_ack_bits = bits;
    @(negedge clk);
    irq_ack_we = 0;
    m_irq &= ~bits;
    chk(irq_status == m_irq, "R10 write-one-to-clear", irq_status, m_irq);
  endtask

  task automatic send_frame(input int len, input bit own, input bit mc, input bit bc,
                            input logic [4:0] err, input bit lose);
    int unsigned fr, a;
    bit spf, expw, filt, good, ovf;
    bit [7:0] seed;
    bit [15:0] stat;
    fr = free_of(); spf = 0; seed = 8'($urandom);
    @(negedge clk);
    rx_valid = 1; rx_byte = seed; rx_last = (len == 1); rx_err = err;
    rx_hit_own = own; rx_hit_mcast = mc; rx_hit_bcast = bc;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (!(foot(k + 5) < fr)) spf = 1;
      expw = (k < MAXF) && !spf;
      chk(mem_we == expw, (k >= MAXF) ? "R12 byte beyond limit" : "R8 byte write enable", mem_we, expw);
      if (expw && mem_we) begin
        a = m_past ? (m_wr + 4 + k) : ((m_wr + 4 + k) % m_size);
        chk(mem_waddr == 15'(a >> 2), m_past ? "R6 run-past word address" : "R5 wrapped word address", mem_waddr, a >> 2);
        chk(mem_be == (4'b0001 << (a % 4)), "R2 byte lane enable", mem_be, 4'b0001 << (a % 4));
        chk(mem_wdata[7:0] == 8'(seed + k) && mem_wdata[31:24] == 8'(seed + k), "R2 byte data", mem_wdata, 8'(seed + k));
      end
      if (k < len - 1) begin
        rx_byte = 8'(seed + k + 1); rx_last = (k + 1 == len - 1);
      end else if (lose) begin
        rx_valid = 1; rx_last = 0; rx_byte = 8'h5A;
      end else begin
        rx_valid = 0; rx_last = 0;
      end
    end
    @(negedge clk);
    filt = (own && cfg_take_own) || (mc && cfg_take_mcast) || (bc && cfg_take_bcast);
    good = filt && (err == 0) && (len <= MAXF) && !spf;
    ovf  = filt && (err == 0) && (len <= MAXF) && spf;
    stat = {mc, own, bc, 12'd0, 1'b1};
    if (good) begin
      chk(mem_we == 1 && mem_be == 4'hF, "R3 header strobe", {mem_we, mem_be}, 5'h1F);
      chk(mem_waddr == 15'(m_wr >> 2), "R3 header address", mem_waddr, m_wr >> 2);
      chk(mem_wdata == {16'(len), stat}, "R3 header contents", mem_wdata, {16'(len), stat});
      m_wr = (m_wr + foot(len + 4)) % m_size;
      m_irq[0] = 1;
    end else begin
      chk(mem_we == 0, (len > MAXF) ? "R12 no header" : (ovf ? "R8 no header" : "R9 no header"), mem_we, 0);
    end
    if (ovf) m_irq[4] = 1;
    if (lose) m_irq[6] = 1;
    check_state(good ? "R4" : (ovf ? "R8" : "R9"));
  endtask

  task automatic fill_to_end(input bit past);
    host_set(m_wr);
    while (m_wr + 1100 < m_size) begin send_frame(1000, 1, 0, 0, 0, 0); host_set(m_wr); end
    while (m_wr + 300 < m_size)  begin send_frame(100, 1, 0, 0, 0, 0);  host_set(m_wr); end
    cfg_run_past = past; m_past = past;
    send_frame(400, 1, 0, 0, 0, 0);
    chk(m_wr < 500, past ? "R6 offset reduced mod ring size" : "R5 offset wrapped", wr_offset, m_wr);
    cfg_run_past = 0; m_past = 0;
    host_set(m_wr);
  endtask

  initial begin
    do_reset(2'd0);
    // Basic acceptance per class.
    send_frame(64, 0, 0, 1, 5'd0, 0);
    send_frame(65, 1, 0, 0, 5'd0, 0);
    send_frame(70, 0, 1, 0, 5'd0, 0);
    // R9 disabled class and error frames.
    cfg_take_mcast = 0;
    send_frame(80, 0, 1, 0, 5'd0, 0);
    cfg_take_mcast = 1;
    send_frame(70, 1, 0, 0, 5'b00100, 0);
    send_frame(70, 0, 0, 0, 5'd0, 0);
    ack(16'h0051);
    // R11 byte lost in the commit slot.
    send_frame(70, 1, 0, 0, 5'd0, 1);
    for (int j = 0; j < 40; j++) begin
      rx_byte = 8'(j); rx_last = (j == 39);
      @(negedge clk);
    end
    rx_valid = 0; rx_last = 0;
    @(negedge clk);
    chk(mem_we == 0, "R11 no header for frame with lost byte", mem_we, 0);
    check_state("R11");
    ack(16'h0040);
    // R12 oversize frame.
    host_set(m_wr);
    send_frame(MAXF + 2, 1, 0, 0, 5'd0, 0);
    // R8 directed overflow: read pointer just ahead.
    host_set(m_wr + 200);
    send_frame(196, 1, 0, 0, 5'd0, 0);
    send_frame(150, 1, 0, 0, 5'd0, 0);
    ack(16'h0011);
    // Constrained random frames.
    for (int n = 0; n < 150; n++) begin
      int len;
      int cls;
      cfg_take_own   = ($urandom % 6) != 0;
      cfg_take_mcast = ($urandom % 4) != 0;
      cfg_take_bcast = ($urandom % 4) != 0;
      len = (($urandom % 8) == 0) ? 800 + int'($urandom % 700) : 60 + int'($urandom % 200);
      cls = int'($urandom % 4);
      send_frame(len, cls == 0, cls == 1, cls == 2,
                 (($urandom % 10) == 0) ? 5'(1 << ($urandom % 5)) : 5'd0, 0);
      if (($urandom % 3) != 0) host_set(m_wr);
      if (($urandom % 4) == 0) ack(16'h0051);
    end
    cfg_take_own = 1; cfg_take_mcast = 1; cfg_take_bcast = 1;
    // R5 wrap mode and R6 run-past across the ring end.
    fill_to_end(0);
    fill_to_end(1);
    // R5 larger ring.
    do_reset(2'd2);
    host_set(16384);
    chk(buf_empty == 0, "R5 32 KiB ring keeps offset 16384 distinct", buf_empty, 0);
    host_set(0);
    send_frame(100, 0, 0, 1, 5'd0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule